// File: doc/BRIEF.md
# Per-Channel Loopback and Squelch Word Datapath

This block sits between a parallel 10-bit line-code interface and the serial bit streams of a multi-channel transceiver. Each channel turns one parallel transmit word into ten serial bits, least-significant bit first, and collects ten received serial bits into one parallel receive word. The first bit received lands in bit 0. All channels share one word timer. The timer raises a tick in the last bit cycle of every word. On the clock edge that ends that cycle, each lane samples its next transmit word and publishes the word it has just received.

Two shared controls steer the serial paths. One is an active-high parallel (internal) loopback. The other is an active-low serial (external echo) loopback. Each channel has its own active-low enable that decides whether the shared controls apply to it at all. A lane takes its effective routing only at a word boundary. A signal-detect flag per channel reports a receive amplitude below threshold. Any such report during a word that came from the external input replaces that received word with all ones. Clock recovery and analog detection lie outside the block. The flag arrives as a plain digital input sampled on the bit clock.

Top module: `lsq_datapath`

## Requirements
- R1: With no loopback in effect, `tx_serial_o` of a channel carries bit k of the word sampled at the last tick edge during the k-th cycle after that edge (k = 0 first, k = 9 last).
- R2: `word_tick_o` is high in exactly one cycle out of every ten, and it is high in the first cycle after reset is released.
- R3: `rx_word_o` changes only on the edge that ends a tick cycle. Its bit k is then the received bit of the k-th cycle of the word just finished, with bit 0 received first.
- R4: A channel whose `lb_en_n_i` bit is 1 at the word boundary ignores `par_lb_i` and `ser_lb_n_i` for the whole word.
- R5: Parallel loopback (`par_lb_i` = 1 on an enabled channel) holds `tx_serial_o` at 1. The receiver takes the channel's own serialized word instead of `rx_serial_i`, so the word reappears on `rx_word_o` after the next boundary.
- R6: Serial loopback (`ser_lb_n_i` = 0 and `par_lb_i` = 0 on an enabled channel) drives `tx_serial_o` with `rx_serial_i` in the same cycle. The receiver still takes `rx_serial_i`.
- R7: When both loopbacks are asserted on an enabled channel, `tx_serial_o` is held at 1 and the receive path takes the internal loopback.
- R8: If `sig_low_i` of a channel is 1 in any cycle of a word received from `rx_serial_i`, that word appears on `rx_word_o` as all ones (0x3FF).
- R9: `sig_low_i` has no effect on a word received through parallel loopback.
- R10: Changes of `par_lb_i`, `ser_lb_n_i` or `lb_en_n_i` in the middle of a word do not alter that word's transmit or receive routing.
- R11: While reset is held, `tx_serial_o` is 1 on every channel, `rx_word_o` is all ones and `word_tick_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| par_lb_i | input | 1 | Shared parallel loopback request, active high |
| ser_lb_n_i | input | 1 | Shared serial loopback request, active low |
| lb_en_n_i | input | NUM_CH | Per-channel loopback enable, active low |
| tx_word_i | input | NUM_CH*WORD_W | Transmit words; channel c uses bits [c*10 +: 10] |
| rx_serial_i | input | NUM_CH | External serial receive bit per channel |
| sig_low_i | input | NUM_CH | Receive amplitude below threshold, per channel |
| tx_serial_o | output | NUM_CH | Serial transmit bit per channel |
| rx_word_o | output | NUM_CH*WORD_W | Received words; channel c on bits [c*10 +: 10] |
| word_tick_o | output | 1 | High in the last bit cycle of each word |

## Verification
On every cycle the assertions check the tick spacing, the hold of the receive bus between boundaries, the first transmitted bit of a channel without loopback, the forced-high output under parallel loopback, and the same-cycle echo under serial loopback. The bench shows what a single-cycle property cannot: whole-word bit order in both directions, the round trip of a word through internal loopback, and squelch across a word together with its exemption under loopback. It also shows that control changes inside a word are ignored. The bench sweeps every combination of the two shared controls and the four enables against varied data and squelch pulses.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    // Effective routing of one lane for one word.
    typedef struct packed {
        logic par;   // internal loopback: tx held high, rx fed from own serializer
        logic ser;   // external echo: tx driven by the serial input
    } lb_cfg_t;

    function automatic lb_cfg_t gate_cfg(input logic par_req, input logic ser_req_n,
                                         input logic en_n);
        lb_cfg_t c;
        c.par = par_req & ~en_n;
        c.ser = ~ser_req_n & ~en_n;
        return c;
    endfunction

endpackage

// File: rtl/lsq_word_timer.sv
module lsq_word_timer #(
    parameter int WORD_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        tick_o = (tmr_q.cnt == LAST);
        if (tick_o) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.cnt <= LAST;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/lsq_lane.sv
module lsq_lane
    import lsq_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              par_lb_i,
    input  logic              ser_lb_n_i,
    input  logic              en_n_i,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic              rx_serial_i,
    input  logic              sig_low_i,
    output logic              tx_serial_o,
    output logic [WORD_W-1:0] rx_word_o
);
    typedef struct packed {
        lb_cfg_t           cfg;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] des;
        logic [WORD_W-1:0] rxw;
        logic              sq;
    } lane_t;

    lane_t ln_d, ln_q;

    logic              ser_bit;
    logic              rx_src;
    logic              sq_any;
    logic [WORD_W-1:0] assembled;

    always_comb begin
        ln_d      = ln_q;
        ser_bit   = ln_q.sh[0];
        rx_src    = ln_q.cfg.par ? ser_bit : rx_serial_i;
        assembled = {rx_src, ln_q.des[WORD_W-1:1]};
        sq_any    = ln_q.sq | (sig_low_i & ~ln_q.cfg.par);

        if (ln_q.cfg.par) begin
            tx_serial_o = 1'b1;
        end else if (ln_q.cfg.ser) begin
            tx_serial_o = rx_serial_i;
        end else begin
            tx_serial_o = ser_bit;
        end

        ln_d.des = assembled;
        if (tick_i) begin
            ln_d.sh  = tx_word_i;
            ln_d.cfg = gate_cfg(par_lb_i, ser_lb_n_i, en_n_i);
            ln_d.rxw = sq_any ? '1 : assembled;
            ln_d.sq  = 1'b0;
        end else begin
            ln_d.sh  = {1'b1, ln_q.sh[WORD_W-1:1]};
            ln_d.sq  = sq_any;
        end

        rx_word_o = ln_q.rxw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q.cfg <= '0;
            ln_q.sh  <= '1;
            ln_q.des <= '0;
            ln_q.rxw <= '1;
            ln_q.sq  <= 1'b0;
        end else begin
            ln_q <= ln_d;
        end
    end
endmodule

// File: rtl/lsq_datapath.sv
module lsq_datapath #(
    parameter int NUM_CH = 4,
    parameter int WORD_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     par_lb_i,
    input  logic                     ser_lb_n_i,
    input  logic [NUM_CH-1:0]        lb_en_n_i,
    input  logic [NUM_CH*WORD_W-1:0] tx_word_i,
    input  logic [NUM_CH-1:0]        rx_serial_i,
    input  logic [NUM_CH-1:0]        sig_low_i,
    output logic [NUM_CH-1:0]        tx_serial_o,
    output logic [NUM_CH*WORD_W-1:0] rx_word_o,
    output logic                     word_tick_o
);
    logic tick;

    lsq_word_timer #(.WORD_W(WORD_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    assign word_tick_o = tick;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        lsq_lane #(.WORD_W(WORD_W)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_i      (tick),
            .par_lb_i    (par_lb_i),
            .ser_lb_n_i  (ser_lb_n_i),
            .en_n_i      (lb_en_n_i[c]),
            .tx_word_i   (tx_word_i[c*WORD_W +: WORD_W]),
            .rx_serial_i (rx_serial_i[c]),
            .sig_low_i   (sig_low_i[c]),
            .tx_serial_o (tx_serial_o[c]),
            .rx_word_o   (rx_word_o[c*WORD_W +: WORD_W])
        );
    end
endmodule

// File: rtl/lsq_datapath_chk.sv
module lsq_datapath_chk #(
    parameter int NUM_CH = 4,
    parameter int WORD_W = 10
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     par_lb_i,
    input logic                     ser_lb_n_i,
    input logic [NUM_CH-1:0]        lb_en_n_i,
    input logic [NUM_CH*WORD_W-1:0] tx_word_i,
    input logic [NUM_CH-1:0]        rx_serial_i,
    input logic [NUM_CH*WORD_W-1:0] rx_word_o,
    input logic [NUM_CH-1:0]        tx_serial_o,
    input logic                     word_tick_o
);
    localparam int GW = $clog2(WORD_W + 1) + 1;

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (word_tick_o) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R2: at most WORD_W-1 cycles without a tick, never two ticks in a row
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q < GW'(WORD_W));
    a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        word_tick_o |=> !word_tick_o);

    // R3: receive bus holds between boundaries
    a_r3_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(word_tick_o)) |-> $stable(rx_word_o));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // R1 / R4: disabled channel sends bit 0 of the sampled word first
        a_r4_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(word_tick_o) && $past(lb_en_n_i[c]))
            |-> (tx_serial_o[c] == $past(tx_word_i[c*WORD_W])));

        // R5 / R7: internal loopback forces the transmit line high
        a_r5_tx_high: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(word_tick_o) && $past(par_lb_i) && !$past(lb_en_n_i[c]))
            |-> tx_serial_o[c]);

        // R6: external echo passes the serial input straight through
        a_r6_echo: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(word_tick_o) && !$past(par_lb_i) && !$past(ser_lb_n_i)
             && !$past(lb_en_n_i[c]))
            |-> (tx_serial_o[c] == rx_serial_i[c]));
    end
endmodule

bind lsq_datapath lsq_datapath_chk #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .par_lb_i    (par_lb_i),
    .ser_lb_n_i  (ser_lb_n_i),
    .lb_en_n_i   (lb_en_n_i),
    .tx_word_i   (tx_word_i),
    .rx_serial_i (rx_serial_i),
    .rx_word_o   (rx_word_o),
    .tx_serial_o (tx_serial_o),
    .word_tick_o (word_tick_o)
);

// File: tb/sim_lsq_datapath.sv
module sim_lsq_datapath;
    localparam int NCH = 4;
    localparam int W   = 10;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               par_lb_i;
    logic               ser_lb_n_i;
    logic [NCH-1:0]     lb_en_n_i;
    logic [NCH*W-1:0]   tx_word_i;
    logic [NCH-1:0]     rx_serial_i;
    logic [NCH-1:0]     sig_low_i;
    logic [NCH-1:0]     tx_serial_o;
    logic [NCH*W-1:0]   rx_word_o;
    logic               word_tick_o;

    always #10 clk = ~clk;

    lsq_datapath #(.NUM_CH(NCH), .WORD_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .par_lb_i(par_lb_i), .ser_lb_n_i(ser_lb_n_i),
        .lb_en_n_i(lb_en_n_i), .tx_word_i(tx_word_i), .rx_serial_i(rx_serial_i),
        .sig_low_i(sig_low_i), .tx_serial_o(tx_serial_o), .rx_word_o(rx_word_o),
        .word_tick_o(word_tick_o)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    bit    exp_valid = 1'b0;
    logic [W-1:0] exp_rx [NCH];
    string        exp_tag [NCH];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Entered at a negedge inside a tick cycle; leaves inside the next one.
    task automatic run_word(input logic plb, input logic slbn, input logic [NCH-1:0] enn,
                            input logic [NCH*W-1:0] words, input logic [NCH*W-1:0] rxpat,
                            input int sq_ch, input int sq_k);
        logic [W-1:0] acc [NCH];
        bit           hit [NCH];
        for (int c = 0; c < NCH; c++) begin
            acc[c] = '0;
            hit[c] = 1'b0;
        end
        par_lb_i   = plb;
        ser_lb_n_i = slbn;
        lb_en_n_i  = enn;
        tx_word_i  = words;
        @(posedge clk);
        for (int k = 0; k < W; k++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                rx_serial_i[c] = rxpat[c*W + k];
                sig_low_i[c]   = (c == sq_ch) && (k == sq_k);
            end
            if (k == W/2) begin
                // R10: scramble the controls mid-word
                par_lb_i   = ~plb;
                ser_lb_n_i = ~slbn;
                lb_en_n_i  = ~enn;
            end
            #1;
            if (k == 0 && exp_valid) begin
                for (int c = 0; c < NCH; c++)
                    chk(rx_word_o[c*W +: W] == exp_rx[c], exp_tag[c],
                        32'(rx_word_o[c*W +: W]), 32'(exp_rx[c]));
            end
            chk(word_tick_o == (k == W-1), "R2 tick", 32'(word_tick_o), 32'(k == W-1));
            for (int c = 0; c < NCH; c++) begin
                logic  p, s, e;
                string tg;
                p = plb & ~enn[c];
                s = ~slbn & ~enn[c];
                e = p ? 1'b1 : (s ? rxpat[c*W + k] : words[c*W + k]);
                tg = enn[c] ? "R4 tx" : (p && s) ? "R7 tx" : p ? "R5 tx" : s ? "R6 tx" : "R1 tx";
                if (k >= W/2) tg = {tg, " R10"};
                chk(tx_serial_o[c] == e, tg, 32'(tx_serial_o[c]), 32'(e));
                acc[c][k] = p ? words[c*W + k] : rxpat[c*W + k];
                if (sig_low_i[c]) hit[c] = 1'b1;
            end
        end
        for (int c = 0; c < NCH; c++) begin
            logic p;
            p = plb & ~enn[c];
            exp_rx[c]  = (hit[c] && !p) ? '1 : acc[c];
            exp_tag[c] = (hit[c] && !p) ? "R8 rx squelch" : (hit[c] ? "R9 rx loopback"
                         : (p ? "R5 rx loopback" : "R3 rx"));
        end
        exp_valid = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0;
        par_lb_i = 1'b0; ser_lb_n_i = 1'b1; lb_en_n_i = '0;
        tx_word_i = '0; rx_serial_i = '0; sig_low_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk(tx_serial_o == '1, "R11 tx", 32'(tx_serial_o), 32'hF);
        chk(rx_word_o == '1, "R11 rx", rx_word_o[31:0], 32'hFFFFFFFF);
        chk(word_tick_o == 1'b1, "R11 tick", 32'(word_tick_o), 32'd1);
        rst_n = 1'b1;
        for (int it = 0; it < 128; it++) begin
            logic [NCH*W-1:0] wds, rxp;
            for (int c = 0; c < NCH; c++) begin
                int a, b;
                a = it * 97 + c * 211 + 5;
                b = (it * 53 + c * 389 + 17) ^ (it << 3);
                if (it % 16 == 3) a = 0;
                if (it % 16 == 7) a = 32'h3FF;
                if (it % 16 == 11) b = 32'h155;
                wds[c*W +: W] = a[W-1:0];
                rxp[c*W +: W] = b[W-1:0];
            end
            run_word(it[0], it[1], it[5:2], wds, rxp, (it / 2) % 5, it % W);
        end
        // flush the last received word
        run_word(1'b0, 1'b1, '1, '0, '0, NCH, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule